// File: doc/BRIEF.md
# Oversampled Bit Phase Recovery

This block sits at the receive side of a serial line that runs eight local clock cycles per bit. The raw line is brought into the local clock domain and cleaned with a five-sample majority filter. A local bit-phase counter is then realigned on qualified falling transitions of the filtered bit, and a one-cycle strobe marks the point near the middle of each bit where a downstream frame decoder should take the bit.

The frame decoder supplies one qualifying input. It is high while the decoder is idle or is expecting the second half of its byte-synchronisation pattern. Only falling transitions seen while that input is high move the sample point. All other transitions leave the phase free-running.

Top module: `bit_phase_rx`

## Requirements
- R1: While rst_ni is low, bit_o is 1 and strobe_o is 0. The phase counter restarts at 1, so the first strobe comes on the 4th rising edge after reset is released and then every 8 edges.
- R2: line_i passes through two flip-flops before any other logic uses it.
- R3: bit_o is the registered majority of five samples: the newest synchronised sample and the four before it. Suppose line_i is first sampled at a new value on edge P0 and holds for n samples, with n from 3 to 7. Then bit_o shows that value after edges P4 through Pn+3.
- R4: A pulse on line_i that lasts one or two samples never changes bit_o.
- R5: A resync event is a 1-to-0 change of bit_o while resync_en_i is high. On the next edge the phase counter loads 2.
- R6: strobe_o is 0 in any cycle that has a resync event.
- R7: strobe_o is high for one cycle whenever the phase counter equals 5. The counter counts 1 through 8 and wraps to 1. Without resync events, strobes are therefore exactly 8 cycles apart.
- R8: After a qualified falling change on line_i first sampled at edge P0, the next strobe is high after edge P8 and the one after that after edge P16, whatever the phase was before.
- R9: Rising changes of bit_o never realign the counter. Neither do falling changes while resync_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sample clock, eight cycles per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Raw serial line, asynchronous to clk_i |
| resync_en_i | input | 1 | High while the frame decoder is idle or expects the second sync bit |
| bit_o | output | 1 | Majority-filtered line value |
| strobe_o | output | 1 | One-cycle pulse at the bit sampling point |

## Verification
Single low pulses of 1, 2, 3, 5 and 7 samples are sent over an idle-high line. They separate spike rejection from real bits and pin down the exact first and last cycle of the filtered output, and with that the latency through both synchroniser stages. A falling change placed so that the old phase would strobe in the resync cycle shows that the strobe is suppressed there. A falling change at a different phase shows that the strobe moves to eight cycles after the change. The same falling change with the qualifier low, and a rising change with it high, must keep the strobe on its old phase.

// File: rtl/bit_phase_pkg.sv
package bit_phase_pkg;
  localparam int unsigned OVERSAMPLE = 8;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned VOTE_LEN = 5;
  localparam int unsigned PHASE_LOAD = 2;
  localparam int unsigned PHASE_STROBE = 5;
  localparam int unsigned MAX_VOTE = 15;

  function automatic int unsigned ones_in(input logic [MAX_VOTE-1:0] bits, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < MAX_VOTE; i++)
      if (i < n && bits[i]) c++;
    return c;
  endfunction
endpackage

// File: rtl/bit_phase_sync.sv
module bit_phase_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bit_phase_vote.sv
module bit_phase_vote
  import bit_phase_pkg::*;
#(
  parameter int unsigned WIN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic vote_o
);
  localparam int unsigned HIST = WIN - 1;
  localparam int unsigned NEED = WIN / 2 + 1;

  logic [HIST-1:0] hist_q;
  logic [MAX_VOTE-1:0] window;
  logic vote_d, vote_q;

  always_comb begin
    window = '0;
    window[HIST:0] = {hist_q, d_i};
    vote_d = (ones_in(window, WIN) >= NEED);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '1;
      vote_q <= 1'b1;
    end else begin
      hist_q <= {hist_q[HIST-2:0], d_i};
      vote_q <= vote_d;
    end
  end

  assign vote_o = vote_q;
endmodule

// File: rtl/bit_phase_ctr.sv
module bit_phase_ctr #(
  parameter int unsigned OVS = 8,
  parameter int unsigned LOAD = 2,
  parameter int unsigned STROBE = 5,
  localparam int unsigned CW = $clog2(OVS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_i,
  input  logic          resync_en_i,
  output logic          resync_o,
  output logic [CW-1:0] cnt_o,
  output logic          strobe_o
);
  logic bit_d_q;
  logic [CW-1:0] cnt_q;
  logic resync;

  // qualified 1->0 change of the voted bit
  assign resync = bit_d_q & ~bit_i & resync_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_d_q <= 1'b1;
      cnt_q   <= CW'(1);
    end else begin
      bit_d_q <= bit_i;
      if (resync)                 cnt_q <= CW'(LOAD);
      else if (cnt_q == CW'(OVS)) cnt_q <= CW'(1);
      else                        cnt_q <= cnt_q + CW'(1);
    end
  end

  assign resync_o = resync;
  assign cnt_o    = cnt_q;
  assign strobe_o = (cnt_q == CW'(STROBE)) && !resync;
endmodule

// File: rtl/bit_phase_rx.sv
module bit_phase_rx
  import bit_phase_pkg::*;
#(
  parameter int unsigned OVS = OVERSAMPLE,
  parameter int unsigned SYNC_N = SYNC_STAGES,
  parameter int unsigned WIN = VOTE_LEN,
  parameter int unsigned LOAD = PHASE_LOAD,
  parameter int unsigned STROBE = PHASE_STROBE,
  localparam int unsigned CW = $clog2(OVS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic resync_en_i,
  output logic bit_o,
  output logic strobe_o
);
  logic line_s;
  logic vote;
  logic resync;
  logic [CW-1:0] cnt;

  if (STROBE <= LOAD || STROBE - LOAD > 3 || STROBE > OVS || LOAD < 1) begin : g_bad_spacing
    $error("bit_phase_rx: strobe minus load must lie in 1..3");
  end

  bit_phase_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s)
  );

  bit_phase_vote #(.WIN(WIN)) u_vote (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_s), .vote_o(vote)
  );

  bit_phase_ctr #(.OVS(OVS), .LOAD(LOAD), .STROBE(STROBE)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(vote), .resync_en_i(resync_en_i),
    .resync_o(resync), .cnt_o(cnt), .strobe_o(strobe_o)
  );

  assign bit_o = vote;
endmodule

// File: rtl/bit_phase_rx_chk.sv
module bit_phase_rx_chk #(
  parameter int unsigned OVS = 8,
  parameter int unsigned LOAD = 2,
  parameter int unsigned STROBE = 5,
  parameter int unsigned CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          line_i,
  input logic          line_s,
  input logic          bit_o,
  input logic          strobe_o,
  input logic          resync,
  input logic [CW-1:0] cnt
);
  logic [2:0] age_q;
  logic [5:0] gap_q, since_q;
  logic seen_q, resync_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0; gap_q <= '0; since_q <= '0;
      seen_q <= 1'b0; resync_pend_q <= 1'b0;
    end else begin
      if (age_q != 3'd7) age_q <= age_q + 3'd1;
      if (strobe_o) begin
        gap_q <= 6'd1; seen_q <= 1'b1; resync_pend_q <= 1'b0;
      end else begin
        if (gap_q != 6'd63) gap_q <= gap_q + 6'd1;
        if (resync) resync_pend_q <= 1'b1;
      end
      if (resync) since_q <= 6'd1;
      else if (since_q != 6'd63) since_q <= since_q + 6'd1;
    end
  end

  a_r2_two_flop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd2) |-> line_s == $past(line_i, 2));

  a_r3_three_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd4 && line_s == $past(line_s) && line_s == $past(line_s, 2)) |=> bit_o == $past(line_s));

  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync |=> cnt == CW'(LOAD));

  a_r6_no_strobe_on_resync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync |-> !strobe_o);

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  a_r7_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && seen_q && !resync_pend_q) |-> gap_q == 6'(OVS));

  a_r7_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt >= CW'(1) && cnt <= CW'(OVS));

  a_r8_resync_distance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && resync_pend_q) |-> since_q == 6'(STROBE - LOAD + 1));
endmodule

bind bit_phase_rx bit_phase_rx_chk #(.OVS(OVS), .LOAD(LOAD), .STROBE(STROBE), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .line_s(line_s),
  .bit_o(bit_o), .strobe_o(strobe_o), .resync(resync), .cnt(cnt)
);

// File: tb/bit_phase_rx_bench.sv
module bit_phase_rx_bench;
  logic clk = 1'b0;
  logic rst_ni, line, en, bit_w, stb_w;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bit_phase_rx u_bit_phase_rx (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .resync_en_i(en),
    .bit_o(bit_w), .strobe_o(stb_w)
  );

  // {pulse length, first low k, last low k}; lo > hi means no low output
  localparam logic [23:0] PULSES [5] = '{
    {8'd1, 8'd15, 8'd0}, {8'd2, 8'd15, 8'd0}, {8'd3, 8'd4, 8'd6},
    {8'd5, 8'd4, 8'd8},  {8'd7, 8'd4, 8'd10}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic align(input int w);
    int g = 0;
    while (!stb_w && g < 32) begin step(); g++; end
    check(g < 32, "R7 strobe present", g, 0);
    repeat (w) step();
  endtask

  // change line; record outputs after edges P0..P16
  task automatic edge_run(input logic v, input logic e, input int w,
                          output logic [16:0] s, output logic [16:0] b);
    align(w);
    en = e; line = v;
    for (int k = 0; k <= 16; k++) begin
      step();
      s[k] = stb_w; b[k] = bit_w;
    end
  endtask

  initial begin
    logic [16:0] s, b;
    logic [14:0] tr, ex;
    rst_ni = 1'b0; line = 1'b1; en = 1'b0;
    repeat (3) @(negedge clk);
    check(bit_w == 1'b1, "R1 bit in reset", bit_w, 1);
    check(stb_w == 1'b0, "R1 strobe in reset", stb_w, 0);
    rst_ni = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      step();
      check(stb_w == (k == 4 || k == 12), "R1 R7 strobe after reset", stb_w, int'(k == 4 || k == 12));
    end

    // pulse table: spikes vs real bits, latency through R2 and R3
    foreach (PULSES[i]) begin
      int len, lo, hi;
      len = int'(PULSES[i][23:16]); lo = int'(PULSES[i][15:8]); hi = int'(PULSES[i][7:0]);
      repeat (16) step();
      line = 1'b0;
      for (int k = 0; k < 15; k++) begin
        step();
        tr[k] = bit_w;
        ex[k] = !(k >= lo && k <= hi);
        if (k == len - 1) line = 1'b1;
      end
      check(tr == ex, (len <= 2) ? "R4 spike trace" : "R2 R3 pulse trace", int'(tr), int'(ex));
    end

    // qualified fall placed on the old strobe slot
    repeat (16) step();
    edge_run(1'b0, 1'b1, 3, s, b);
    check(b[3] == 1'b1 && b[4] == 1'b0, "R3 fall latency", int'(b[4:3]), 1);
    check(s[4] == 1'b0, "R6 strobe in resync cycle", s[4], 0);
    check(s[7:5] == 3'b000 && s[8] == 1'b1, "R8 strobe at P8", int'(s[8:5]), 8);
    check(s[16] == 1'b1 && s[15:9] == '0, "R7 period after resync", int'(s[16:9]), 8'h80);

    // rising change with qualifier high
    edge_run(1'b1, 1'b1, 3, s, b);
    check(s[4] == 1'b1 && s[8] == 1'b0, "R9 rising keeps phase", int'({s[8], s[4]}), 1);

    // falling change with qualifier low
    edge_run(1'b0, 1'b0, 3, s, b);
    check(s[4] == 1'b1 && s[8] == 1'b0, "R9 unqualified fall keeps phase", int'({s[8], s[4]}), 1);

    // back to high, then qualified fall at another phase
    edge_run(1'b1, 1'b0, 3, s, b);
    edge_run(1'b0, 1'b1, 1, s, b);
    check(s[16:5] == 12'h808, "R5 R8 realigned strobes", int'(s[16:5]), 12'h808);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule